// File: doc/BRIEF.md
# Inter-Core Mailbox Interrupt Controller

This block lets the cores of a small multiprocessor interrupt one another and hand over a 16-bit message in the process. Each core has two 32-bit registers in a shared register window: a control word and a status word. It also has one interrupt output. A core sends a message by writing its own control word with the send bit set, the destination core index and the payload. In the status word of the destination core this sets a pending flag and records the sender's index and the payload. It also raises the destination core's interrupt line.

The receiving core reads its status word to learn the sender and the message. It then writes its own control word with the release bit set. This clears the pending flag and drops its line, while the sender and payload fields keep their values. The register bus has one access per cycle. Read data is combinational from the address, and writes take effect at the next rising clock edge. The core count is a parameter from 1 to 4, and the window size is the core count times 8 bytes.

Top module: `ipi_mbox`

## Requirements
- R1: While reset is asserted, every control and status word is cleared and every interrupt output is driven low.
- R2: Byte address bits [ADDR_W-1:3] select the core slot and bit 2 selects the word (0 = control, 1 = status). A write to the control word of an existing core stores all 32 bits at the next clock edge, and a read returns that word unchanged.
- R3: In a control word, bit 30 is the send request, bits 29:16 are the destination index and bits 15:0 are the payload. A write with bit 30 set replaces the destination's status word with {1'b0, 1'b1, sender index[13:0], payload[15:0]}.
- R4: A send raises the destination's interrupt output at the next clock edge. The line stays high through any other traffic until that destination core releases it.
- R5: A control write with bit 31 (release) set clears only bit 30 of the writer's own status word and lowers its interrupt at the next edge. The sender and payload fields are kept, and other cores are not affected.
- R6: A write aimed at a status word changes no register and no interrupt output. A read of a status word returns its current value.
- R7: If one write sets both send and release, the send is applied first and the release second. A core that sends to itself in this way ends up with the new sender and payload fields, pending clear and its line low.
- R8: An access whose slot index is at or above NUM_CORES is ignored: a write changes nothing and a read returns zero.
- R9: A write with the send bit set whose destination index is at or above NUM_CORES is dropped whole: no control word is stored, and no status word or interrupt changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| core_irq | output | NUM_CORES | One interrupt line per core |

## Verification
Read data is valid in the same cycle the address is presented. Every write changes registers and interrupt lines exactly one rising edge after it is accepted. The bench drives each access on a falling edge and removes it on the next falling edge. It then reads back every word of every core and compares every interrupt line against its own model, all before the next access, so each check lands one edge after the write that caused it. A sweep covers every sender and destination pair with varied payloads, followed by the release, combined and ignored cases.

// File: rtl/ipi_mbox_pkg.sv
package ipi_mbox_pkg;
  localparam int WORD_W   = 32;
  localparam int IDX_W    = 14;
  localparam int PAY_W    = 16;
  localparam int BIT_REL  = 31;
  localparam int BIT_SEND = 30;
  localparam int MAX_CORES = 4;

  // status image of a freshly delivered message
  function automatic logic [WORD_W-1:0] mk_status(input logic [IDX_W-1:0] src,
                                                  input logic [PAY_W-1:0] pay);
    mk_status = {1'b0, 1'b1, src, pay};
  endfunction

  function automatic logic [IDX_W-1:0] dest_of(input logic [WORD_W-1:0] w);
    dest_of = w[29:16];
  endfunction
endpackage

// File: rtl/ipi_mbox_decode.sv
module ipi_mbox_decode
  import ipi_mbox_pkg::*;
#(
  parameter int NUM_CORES = 1,
  parameter int ADDR_W    = 8
) (
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [IDX_W-1:0]  slot_idx,
  output logic [IDX_W-1:0]  dst_idx,
  output logic              is_status,
  output logic              rd_ok,
  output logic              wr_ok
);
  logic [31:0] slot_full;
  logic        slot_ok, dst_ok, send_req;
  logic        unused_lsb;

  assign unused_lsb = ^addr[1:0];
  assign slot_full  = 32'(addr >> 3);
  assign slot_ok    = slot_full < 32'(NUM_CORES);
  assign slot_idx   = slot_full[IDX_W-1:0];
  assign dst_idx    = dest_of(wdata);
  assign dst_ok     = 32'(dst_idx) < 32'(NUM_CORES);
  assign send_req   = wdata[BIT_SEND];
  assign is_status  = addr[2];
  assign rd_ok      = sel && !we && slot_ok;
  assign wr_ok      = sel && we && slot_ok && !is_status && !(send_req && !dst_ok);
endmodule

// File: rtl/ipi_mbox_slot.sv
module ipi_mbox_slot
  import ipi_mbox_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic              gen_hit,
  input  logic              rel_hit,
  input  logic [WORD_W-1:0] wdata,
  input  logic [IDX_W-1:0]  src_idx,
  output logic [WORD_W-1:0] ctrl_q,
  output logic [WORD_W-1:0] status_q,
  output logic              irq
);
  logic [WORD_W-1:0] status_d;

  always_comb begin
    status_d = status_q;
    if (gen_hit) status_d = mk_status(src_idx, wdata[PAY_W-1:0]);
    if (rel_hit) status_d[BIT_SEND] = 1'b0;   // release applied after send
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      status_q <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= wdata;
      status_q <= status_d;
    end
  end

  assign irq = status_q[BIT_SEND];

  // R2: control word holds what was written
  p_ctrl_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> ctrl_q == $past(wdata));
  // R3: delivered message carries the payload and raises pending
  p_deliver_r3: assert property (@(posedge clk) disable iff (!rst_n)
    gen_hit && !rel_hit |=> irq && status_q[15:0] == $past(wdata[15:0]));
  // R4: no event, no change
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_hit && !rel_hit |=> $stable(status_q));
  // R5 / R7: release always ends low, fields untouched unless a send coincided
  p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rel_hit |=> !irq);
  p_keep_fields_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rel_hit && !gen_hit |=> status_q[29:0] == $past(status_q[29:0]));
endmodule

// File: rtl/ipi_mbox.sv
module ipi_mbox
  import ipi_mbox_pkg::*;
#(
  parameter int NUM_CORES = 1,
  parameter int ADDR_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic [NUM_CORES-1:0] core_irq
);
  logic [IDX_W-1:0]  slot_idx, dst_idx;
  logic              is_status, rd_ok, wr_ok;
  logic [WORD_W-1:0] ctrl_w [NUM_CORES];
  logic [WORD_W-1:0] stat_w [NUM_CORES];
  logic [NUM_CORES-1:0] ctrl_wr_v, gen_v, rel_v;

  ipi_mbox_decode #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) u_dec (
    .sel(bus_sel), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .slot_idx(slot_idx), .dst_idx(dst_idx), .is_status(is_status),
    .rd_ok(rd_ok), .wr_ok(wr_ok)
  );

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_slot
    assign ctrl_wr_v[g] = wr_ok && slot_idx == IDX_W'(g);
    assign rel_v[g]     = ctrl_wr_v[g] && bus_wdata[BIT_REL];
    assign gen_v[g]     = wr_ok && bus_wdata[BIT_SEND] && dst_idx == IDX_W'(g);

    ipi_mbox_slot u_slot (
      .clk(clk), .rst_n(rst_n),
      .ctrl_wr(ctrl_wr_v[g]), .gen_hit(gen_v[g]), .rel_hit(rel_v[g]),
      .wdata(bus_wdata), .src_idx(slot_idx),
      .ctrl_q(ctrl_w[g]), .status_q(stat_w[g]), .irq(core_irq[g])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_CORES; i++)
      if (rd_ok && slot_idx == IDX_W'(i))
        bus_rdata = is_status ? stat_w[i] : ctrl_w[i];
  end

  // R1: reset leaves every line low
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> core_irq == '0);
  // R6: status-word writes touch nothing
  p_status_wr_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && bus_we && is_status |=> $stable(core_irq));
  // R8 / R9: rejected writes leave lines alone
  p_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && bus_we && !wr_ok |=> $stable(core_irq));
  // R3: at most one destination per write
  p_one_dest_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gen_v));
endmodule

// File: tb/ipi_mbox_test.sv
module ipi_mbox_test;
  localparam int N  = 4;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0, bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  core_irq;

  int n_chk = 0, n_bad = 0;
  logic [31:0] m_ctrl [N];
  logic [31:0] m_stat [N];

  always #2.5 clk = ~clk;

  ipi_mbox #(.NUM_CORES(N), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .core_irq(core_irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    int c;
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    // model from the requirements
    c = a / 8;
    if ((a & 4) != 0 || c >= N) return;                 // R6, R8
    if (d[30] && int'(d[29:16]) >= N) return;           // R9
    m_ctrl[c] = d;                                      // R2
    if (d[30]) m_stat[d[29:16]] = 32'h4000_0000 | (c << 16) | {16'h0, d[15:0]}; // R3
    if (d[31]) m_stat[c][30] = 1'b0;                    // R5, R7
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = AW'(a);
    #1 v = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic verify(input string tag);
    logic [31:0] v;
    for (int i = 0; i < N; i++) begin
      rd(i * 8, v);     check({tag, " ctrl"}, v, m_ctrl[i]);
      rd(i * 8 + 4, v); check({tag, " status"}, v, m_stat[i]);
      check({tag, " irq"}, 32'(core_irq[i]), 32'(m_stat[i][30]));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got hang expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < N; i++) begin m_ctrl[i] = '0; m_stat[i] = '0; end
    repeat (3) @(negedge clk);
    check("R1 irq in reset", 32'(core_irq), 32'h0);
    rst_n = 1'b1;
    verify("R1 reset state");

    // R2: plain control stores
    wr(8, 32'h0000_5A5A); verify("R2 store");
    wr(24, 32'h0003_1234); verify("R2 store no send");

    // R3 / R4 / R5 sweep over every pair
    for (int s = 0; s < N; s++)
      for (int d = 0; d < N; d++) begin
        logic [15:0] pay;
        pay = 16'((s * 37 + d * 4099) ^ 16'hA5C3);
        wr(s * 8, {2'b01, 14'(d), pay});
        verify("R3 R4 send");
        wr(((d + 1) % N) * 8, 32'h0000_0001);
        verify("R4 line held");
        wr(d * 8, 32'h8000_0000);
        verify("R5 release");
      end

    // R5: release leaves other pending lines alone
    wr(0, {2'b01, 14'd2, 16'h1111});
    wr(8, {2'b01, 14'd3, 16'h2222});
    wr(16, 32'h8000_0000);
    verify("R5 only own");
    check("R5 core3 still high", 32'(core_irq[3]), 32'h1);

    // R6: status writes ignored
    wr(28, 32'hFFFF_FFFF); verify("R6 status write");
    rd(28, v); check("R6 status read", v, {2'b01, 14'd1, 16'h2222});

    // R7: both bits, self and other
    wr(8, {2'b11, 14'd1, 16'hBEEF}); verify("R7 self send+release");
    check("R7 self fields", m_stat[1], 32'h0001_BEEF);
    wr(0, {2'b01, 14'd0, 16'h0F0F});
    wr(0, {2'b11, 14'd2, 16'h7777}); verify("R7 send other + release own");

    // R8: out-of-range slots
    wr(32, 32'h4000_0001); verify("R8 write oor");
    rd(32, v); check("R8 read oor ctrl", v, 32'h0);
    rd(44, v); check("R8 read oor status", v, 32'h0);

    // R9: send to non-existent core
    wr(16, {2'b11, 14'd4, 16'h9999}); verify("R9 dest oor");
    wr(16, {2'b01, 14'h3FFF, 16'h1}); verify("R9 dest max");

    // R1: reset again mid-traffic
    wr(0, {2'b01, 14'd3, 16'h4242});
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < N; i++) begin m_ctrl[i] = '0; m_stat[i] = '0; end
    verify("R1 reset clears");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule